// File: doc/BRIEF.md
# Max-approximated GMM state scorer

This block scores one hidden-Markov-model state at a time against a batch of buffered feature frames. Each mixture of the state arrives once on a beat-serial parameter stream: a constant, then a mean and a precomputed inverse variance for each feature dimension. Every beat is applied at once to all `FRAMES` frames held in a local feature store. Each frame accumulates a saturating weighted squared distance. When a mixture ends, its score is the constant minus that distance. The state score of a frame is the largest mixture score of the state; no log-add is performed.

State scores are written into one of two result banks. A downstream search engine reads the other bank through a combinational read port. When the producer has finished a batch and the consumer has released the bank it was reading, the banks swap and the fresh results become visible. If the batch finishes first, the parameter stream is stalled through `p_ready` until the consumer releases.

Top module: `gmm_state_scorer`

## Requirements
- R1: For frame f and one mixture, each dimension d adds floor(((x[f][d] - mean[d])^2 * ivar[d]) / 2^(IVAR_FRAC+1)), where x and mean are signed FEAT_W-bit values and ivar is an unsigned IVAR_W-bit value. The mixture score is the signed ACC_W-bit constant minus the sum over all DIM dimensions.
- R2: The stored state score of a frame is the maximum of the mixture scores of that state. The running maximum starts again from -2^(ACC_W-1) for every state, so no score carries over from an earlier state.
- R3: Every parameter beat is applied to all FRAMES frames in the same cycle. The k-th state of a batch (counted from 0) is stored at read address state=k, with one entry per frame index.
- R4: The distance sum saturates at 2^(ACC_W-1)-1 instead of wrapping. A mixture score below -2^(ACC_W-1) is clamped to -2^(ACC_W-1).
- R5: A mixture takes exactly DIM accepted beats, with dimension 0 first. The constant is taken only from the first beat. The mixture-last and state-last flags are used only on the final beat of a mixture and have no effect on any other beat.
- R6: `done` is high for exactly one cycle, in the cycle after the accepted final beat of the last mixture of the last state of a batch.
- R7: Once the batch has finished and the consumer has released its bank (the consumer starts out released after reset), the banks swap. From the following cycle `res_swap` is high for one cycle and the read port shows the new batch. Until the swap, the read port keeps showing the previous bank, unaffected by producer writes.
- R8: While a finished batch waits for the consumer, `p_ready` is low and beats offered on `p_valid` are ignored. `p_ready` returns high in the cycle after the swap, and the next batch starts at dimension 0 of a new state 0.
- R9: After reset, `p_ready` is high and `done` and `res_swap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one feature element |
| ld_frame | input | FR_AW | Frame index of the written element |
| ld_dim | input | DIM_AW | Dimension index of the written element |
| ld_value | input | FEAT_W | Signed feature value |
| p_valid | input | 1 | Parameter beat offered |
| p_ready | output | 1 | Parameter beat accepted when high |
| p_const | input | ACC_W | Signed mixture constant (first beat of a mixture) |
| p_mean | input | FEAT_W | Signed mean for the current dimension |
| p_ivar | input | IVAR_W | Unsigned inverse variance, IVAR_FRAC fraction bits |
| p_mix_last | input | 1 | On the final beat: last mixture of the state |
| p_batch_last | input | 1 | On the final beat of the last mixture: last state of the batch |
| cons_release | input | 1 | Consumer pulse: done with its bank |
| rd_state | input | ST_AW | Read address: state within batch |
| rd_frame | input | FR_AW | Read address: frame |
| rd_score | output | ACC_W | Signed state score from the consumer bank |
| done | output | 1 | One-cycle pulse at batch end |
| res_swap | output | 1 | One-cycle pulse after the banks swap |

## Verification
The hardest situation to reach is a finished batch stalled against a consumer that has not let go. In that state the read port must keep presenting the old batch, while junk beats on the stream must leave the dimension count untouched. The stimulus gets there with a second batch that runs without a release after the first swap. It then offers several beats while `p_ready` is low and only afterwards pulses the release. A third, short batch then checks that mixture alignment survived. Saturation is reached with extreme means and inverse variances on some mixtures. In one of them the clamped sum leaves a score of exactly zero, and in another the score is clamped to the negative limit.

// File: rtl/gmm_pkg.sv
package gmm_pkg;

   // control that the beat sequencer hands to every frame lane
   typedef struct packed {
      logic fire;       // a beat is accepted this cycle
      logic first_dim;  // beat carries dimension 0
      logic last_dim;   // beat carries the final dimension
      logic first_mix;  // beat belongs to the first mixture of a state
   } beat_ctl_t;

   function automatic int addr_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/gmm_beat_seq.sv
module gmm_beat_seq
   import gmm_pkg::*;
#(
   parameter int DIM    = 4,
   parameter int STATES = 8,
   localparam int DIM_AW = addr_w(DIM),
   localparam int ST_AW  = addr_w(STATES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              mix_last,
   input  logic              batch_last,
   output beat_ctl_t         ctl,
   output logic [DIM_AW-1:0] dim_idx,
   output logic              st_wr,
   output logic [ST_AW-1:0]  st_idx,
   output logic              batch_end
);

   logic [DIM_AW-1:0] dim_cnt;
   logic [ST_AW-1:0]  st_cnt;
   logic              fresh_state;
   logic              mix_done;

   assign dim_idx       = dim_cnt;
   assign st_idx        = st_cnt;
   assign ctl.fire      = fire;
   assign ctl.first_dim = (dim_cnt == '0);
   assign ctl.last_dim  = (dim_cnt == DIM_AW'(DIM - 1));
   assign ctl.first_mix = fresh_state;

   assign mix_done  = fire & ctl.last_dim;
   assign st_wr     = mix_done & mix_last;
   assign batch_end = st_wr & batch_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dim_cnt     <= '0;
         st_cnt      <= '0;
         fresh_state <= 1'b1;
      end else begin
         if (fire) begin
            dim_cnt <= ctl.last_dim ? '0 : dim_cnt + DIM_AW'(1);
         end
         if (mix_done) begin
            fresh_state <= mix_last;
         end
         if (st_wr) begin
            if (batch_last || st_cnt == ST_AW'(STATES - 1)) begin
               st_cnt <= '0;
            end else begin
               st_cnt <= st_cnt + ST_AW'(1);
            end
         end
      end
   end

   // R5: dimension counter never leaves the valid range
   a_r5_dim_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      dim_cnt <= DIM_AW'(DIM - 1));

   // R5: a non-final beat always advances to the next dimension
   a_r5_dim_step : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dim_cnt != DIM_AW'(DIM - 1)) |=> dim_cnt == $past(dim_cnt) + DIM_AW'(1));

endmodule

// File: rtl/gmm_frame_lane.sv
module gmm_frame_lane
   import gmm_pkg::*;
#(
   parameter int FEAT_W    = 8,
   parameter int IVAR_W    = 8,
   parameter int IVAR_FRAC = 6,
   parameter int ACC_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  beat_ctl_t         ctl,
   input  logic [FEAT_W-1:0] x,
   input  logic [FEAT_W-1:0] mean,
   input  logic [IVAR_W-1:0] ivar,
   input  logic [ACC_W-1:0]  cst,
   output logic [ACC_W-1:0]  best
);

   localparam int DIFF_W = FEAT_W + 1;
   localparam int SQ_W   = 2 * DIFF_W;
   localparam int PROD_W = SQ_W + IVAR_W;
   localparam int SUM_W  = ((PROD_W > ACC_W) ? PROD_W : ACC_W) + 1;
   localparam int SHIFT  = IVAR_FRAC + 1;
   localparam logic [ACC_W-1:0] SAT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   logic signed [DIFF_W-1:0] diff;
   logic signed [SQ_W-1:0]   sq_s;
   logic [PROD_W-1:0]        prod;
   logic [SUM_W-1:0]         term;
   logic [SUM_W-1:0]         base;
   logic [SUM_W-1:0]         tot;
   logic [ACC_W-1:0]         sum_sat;
   logic signed [ACC_W:0]    sc_w;
   logic [ACC_W-1:0]         score;
   logic [ACC_W-1:0]         cand;
   logic [ACC_W-1:0]         acc;
   logic [ACC_W-1:0]         runmax;

   always_comb begin
      diff = $signed({x[FEAT_W-1], x}) - $signed({mean[FEAT_W-1], mean});
      sq_s = diff * diff;
      prod = {{IVAR_W{1'b0}}, sq_s} * {{SQ_W{1'b0}}, ivar};
      term = SUM_W'(prod >> SHIFT);
      base = ctl.first_dim ? '0 : SUM_W'(acc);
      tot  = base + term;
      sum_sat = (tot > SUM_W'(SAT_MAX)) ? SAT_MAX : tot[ACC_W-1:0];
      sc_w  = $signed({cst[ACC_W-1], cst}) - $signed({1'b0, sum_sat});
      score = (sc_w < $signed({1'b1, NEG_MIN})) ? NEG_MIN : sc_w[ACC_W-1:0];
      cand  = ctl.first_mix ? NEG_MIN : runmax;
      best  = ($signed(score) > $signed(cand)) ? score : cand;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         runmax <= NEG_MIN;
      end else if (ctl.fire) begin
         acc <= sum_sat;
         if (ctl.last_dim) begin
            runmax <= best;
         end
      end
   end

   // R4: the stored distance never exceeds the positive limit
   a_r4_acc_capped : assert property (@(posedge clk) disable iff (!rst_n)
      acc <= SAT_MAX);

   // R2: within one state the running maximum only grows
   a_r2_max_grows : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.fire && ctl.last_dim && !ctl.first_mix)
         |=> $signed(runmax) >= $signed($past(runmax)));

endmodule

// File: rtl/gmm_result_bank.sv
module gmm_result_bank
   import gmm_pkg::*;
#(
   parameter int ACC_W  = 16,
   parameter int FRAMES = 20,
   parameter int STATES = 8,
   localparam int FR_AW = addr_w(FRAMES),
   localparam int ST_AW = addr_w(STATES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ST_AW-1:0]        wr_state,
   input  logic [FRAMES*ACC_W-1:0] wr_data,
   input  logic                    batch_end,
   input  logic                    cons_release,
   input  logic [ST_AW-1:0]        rd_state,
   input  logic [FR_AW-1:0]        rd_frame,
   output logic [ACC_W-1:0]        rd_score,
   output logic                    prod_hold,
   output logic                    swap_pulse
);

   logic [ACC_W-1:0] mem [2][STATES][FRAMES];
   logic             bank;
   logic             pend_p;
   logic             pend_c;
   logic             np;
   logic             nc;
   logic             do_swap;

   always_comb begin
      np      = pend_p | batch_end;
      nc      = pend_c | cons_release;
      do_swap = np & nc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank       <= 1'b0;
         pend_p     <= 1'b0;
         pend_c     <= 1'b1;
         swap_pulse <= 1'b0;
      end else begin
         swap_pulse <= do_swap;
         if (do_swap) begin
            bank   <= ~bank;
            pend_p <= 1'b0;
            pend_c <= 1'b0;
         end else begin
            pend_p <= np;
            pend_c <= nc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int f = 0; f < FRAMES; f++) begin
            mem[bank][wr_state][f] <= wr_data[f*ACC_W +: ACC_W];
         end
      end
   end

   assign rd_score  = mem[~bank][rd_state][rd_frame];
   assign prod_hold = pend_p;

   // R8: a stalled producer stays stalled until the consumer lets go
   a_r8_hold_until_release : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_p && !cons_release) |=> pend_p);

   // R7: the swap pulse follows a bank change
   a_r7_flip_on_swap : assert property (@(posedge clk) disable iff (!rst_n)
      swap_pulse |-> bank != $past(bank));

   // R7: without a swap the consumer bank holds still
   a_r7_bank_steady : assert property (@(posedge clk) disable iff (!rst_n)
      !swap_pulse |-> bank == $past(bank));

endmodule

// File: rtl/gmm_state_scorer.sv
module gmm_state_scorer
   import gmm_pkg::*;
#(
   parameter int FEAT_W    = 8,
   parameter int IVAR_W    = 8,
   parameter int IVAR_FRAC = 6,
   parameter int ACC_W     = 16,
   parameter int DIM       = 4,
   parameter int FRAMES    = 20,
   parameter int STATES    = 8,
   localparam int FR_AW  = addr_w(FRAMES),
   localparam int DIM_AW = addr_w(DIM),
   localparam int ST_AW  = addr_w(STATES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [FR_AW-1:0]  ld_frame,
   input  logic [DIM_AW-1:0] ld_dim,
   input  logic [FEAT_W-1:0] ld_value,
   input  logic              p_valid,
   output logic              p_ready,
   input  logic [ACC_W-1:0]  p_const,
   input  logic [FEAT_W-1:0] p_mean,
   input  logic [IVAR_W-1:0] p_ivar,
   input  logic              p_mix_last,
   input  logic              p_batch_last,
   input  logic              cons_release,
   input  logic [ST_AW-1:0]  rd_state,
   input  logic [FR_AW-1:0]  rd_frame,
   output logic [ACC_W-1:0]  rd_score,
   output logic              done,
   output logic              res_swap
);

   // elaboration-time parameter checks
   if (DIM < 2) begin : g_bad_dim
      $error("gmm_state_scorer: DIM must be at least 2");
   end
   if (FRAMES < 1 || STATES < 1) begin : g_bad_count
      $error("gmm_state_scorer: FRAMES and STATES must be positive");
   end
   if (ACC_W < 4 || FEAT_W < 2 || IVAR_W < 1) begin : g_bad_width
      $error("gmm_state_scorer: widths too small");
   end
   if (IVAR_FRAC < 0 || IVAR_FRAC + 1 >= 2 * (FEAT_W + 1) + IVAR_W) begin : g_bad_frac
      $error("gmm_state_scorer: IVAR_FRAC out of range");
   end

   logic [FEAT_W-1:0]       feat_mem [FRAMES][DIM];
   logic [ACC_W-1:0]        cst_q;
   logic                    hold;
   logic                    fire;
   beat_ctl_t               ctl;
   logic [DIM_AW-1:0]       dim_idx;
   logic                    st_wr;
   logic [ST_AW-1:0]        st_idx;
   logic                    batch_end;
   logic [FRAMES*ACC_W-1:0] lane_best;

   assign p_ready = ~hold;
   assign fire    = p_valid & ~hold;

   always_ff @(posedge clk) begin
      if (ld_en) begin
         feat_mem[ld_frame][ld_dim] <= ld_value;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cst_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= batch_end;
         if (fire && ctl.first_dim) begin
            cst_q <= p_const;
         end
      end
   end

   gmm_beat_seq #(
      .DIM    (DIM),
      .STATES (STATES)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .mix_last   (p_mix_last),
      .batch_last (p_batch_last),
      .ctl        (ctl),
      .dim_idx    (dim_idx),
      .st_wr      (st_wr),
      .st_idx     (st_idx),
      .batch_end  (batch_end)
   );

   for (genvar f = 0; f < FRAMES; f++) begin : g_lane
      gmm_frame_lane #(
         .FEAT_W    (FEAT_W),
         .IVAR_W    (IVAR_W),
         .IVAR_FRAC (IVAR_FRAC),
         .ACC_W     (ACC_W)
      ) i_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .ctl   (ctl),
         .x     (feat_mem[f][dim_idx]),
         .mean  (p_mean),
         .ivar  (p_ivar),
         .cst   (cst_q),
         .best  (lane_best[f*ACC_W +: ACC_W])
      );
   end

   gmm_result_bank #(
      .ACC_W  (ACC_W),
      .FRAMES (FRAMES),
      .STATES (STATES)
   ) i_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (st_wr),
      .wr_state     (st_idx),
      .wr_data      (lane_best),
      .batch_end    (batch_end),
      .cons_release (cons_release),
      .rd_state     (rd_state),
      .rd_frame     (rd_frame),
      .rd_score     (rd_score),
      .prod_hold    (hold),
      .swap_pulse   (res_swap)
   );

   // R6: the batch-end pulse lasts a single cycle
   a_r6_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: no beat is taken while the producer waits for the consumer
   a_r8_stall_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      (!p_ready && p_valid) |=> $stable(dim_idx));

endmodule

// File: tb/test_gmm_state_scorer.sv
module test_gmm_state_scorer;

   localparam int DIM   = 4;
   localparam int FR    = 20;
   localparam int ST    = 8;
   localparam int SHIFT = 7;
   localparam int MAXV  = 32767;
   localparam int MINV  = -32768;
   localparam int MAXM  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [4:0]  ld_frame = '0;
   logic [1:0]  ld_dim = '0;
   logic [7:0]  ld_value = '0;
   logic        p_valid = 1'b0;
   logic        p_ready;
   logic [15:0] p_const = '0;
   logic [7:0]  p_mean = '0;
   logic [7:0]  p_ivar = '0;
   logic        p_mix_last = 1'b0;
   logic        p_batch_last = 1'b0;
   logic        cons_release = 1'b0;
   logic [2:0]  rd_state = '0;
   logic [4:0]  rd_frame = '0;
   logic [15:0] rd_score;
   logic        done;
   logic        res_swap;

   always #10 clk = ~clk;

   gmm_state_scorer i_gmm_state_scorer (
      .clk (clk), .rst_n (rst_n),
      .ld_en (ld_en), .ld_frame (ld_frame), .ld_dim (ld_dim), .ld_value (ld_value),
      .p_valid (p_valid), .p_ready (p_ready), .p_const (p_const), .p_mean (p_mean),
      .p_ivar (p_ivar), .p_mix_last (p_mix_last), .p_batch_last (p_batch_last),
      .cons_release (cons_release), .rd_state (rd_state), .rd_frame (rd_frame),
      .rd_score (rd_score), .done (done), .res_swap (res_swap)
   );

   int total = 0;
   int bad = 0;
   int feat [FR][DIM];
   int exp_prod [ST][FR];
   bit prod_ok [ST][FR];
   int exp_view [ST][FR];
   bit view_ok [ST][FR];
   int mix_mode [MAXM];
   int cur_c [MAXM];
   int cur_mu [MAXM][DIM];
   int cur_iv [MAXM][DIM];

   // behavioural model of the handshake, advanced on every clock
   bit m_pend_p = 1'b0;
   bit m_pend_c = 1'b1;
   int m_dcnt = 0;
   bit m_done = 1'b0;
   bit m_swap = 1'b0;
   bit live = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend_p = 1'b0; m_pend_c = 1'b1; m_dcnt = 0; m_done = 1'b0; m_swap = 1'b0;
      end else begin
         bit fire, endb, np, nc;
         fire = p_valid && !m_pend_p;
         endb = 1'b0;
         if (fire) begin
            if (m_dcnt == DIM - 1) begin
               endb = p_mix_last && p_batch_last;
               m_dcnt = 0;
            end else begin
               m_dcnt++;
            end
         end
         m_done = endb;
         np = m_pend_p || endb;
         nc = m_pend_c || cons_release;
         m_swap = np && nc;
         if (m_swap) begin
            exp_view = exp_prod;
            view_ok = prod_ok;
            m_pend_p = 1'b0; m_pend_c = 1'b0;
         end else begin
            m_pend_p = np; m_pend_c = nc;
         end
      end
   end

   // every clock: handshake outputs and the consumer view
   always @(negedge clk) begin
      #2;
      if (rst_n && live) begin
         chk(p_ready == !m_pend_p, "R8 p_ready", int'(p_ready), int'(!m_pend_p));
         chk(done == m_done, "R6 done", int'(done), int'(m_done));
         chk(res_swap == m_swap, "R7 res_swap", int'(res_swap), int'(m_swap));
         if (view_ok[rd_state][rd_frame])
            chk(int'($signed(rd_score)) == exp_view[rd_state][rd_frame], "R7 view",
                int'($signed(rd_score)), exp_view[rd_state][rd_frame]);
      end
   end

   task automatic load_feats();
      for (int f = 0; f < FR; f++) begin
         for (int d = 0; d < DIM; d++) begin
            @(negedge clk);
            feat[f][d] = int'($urandom_range(80)) - 40;
            ld_en = 1'b1; ld_frame = 5'(f); ld_dim = 2'(d); ld_value = 8'(feat[f][d]);
         end
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic clear_prod();
      for (int s = 0; s < ST; s++)
         for (int f = 0; f < FR; f++) prod_ok[s][f] = 1'b0;
   endtask

   // R1 R2 R4: expected state score computed from the arithmetic rules
   task automatic run_state(input int s, input int nmix, input bit last_st, input bit noise);
      for (int m = 0; m < nmix; m++) begin
         for (int d = 0; d < DIM; d++) begin
            case (mix_mode[m])
               0: begin cur_mu[m][d] = int'($urandom_range(80)) - 40; cur_iv[m][d] = int'($urandom_range(127)); end
               3: begin cur_mu[m][d] = 0; cur_iv[m][d] = 0; end
               default: begin cur_mu[m][d] = -128; cur_iv[m][d] = 255; end
            endcase
         end
         case (mix_mode[m])
            0: cur_c[m] = int'($urandom_range(4000)) - 2000;
            1: cur_c[m] = -30000;
            2: cur_c[m] = 32767;
            default: cur_c[m] = 30000;
         endcase
      end
      for (int f = 0; f < FR; f++) begin
         int best = MINV;
         for (int m = 0; m < nmix; m++) begin
            int sum = 0;
            int sc;
            for (int d = 0; d < DIM; d++) begin
               int df = feat[f][d] - cur_mu[m][d];
               sum += (df * df * cur_iv[m][d]) >>> SHIFT;
               if (sum > MAXV) sum = MAXV;
            end
            sc = cur_c[m] - sum;
            if (sc < MINV) sc = MINV;
            if (sc > best) best = sc;
         end
         exp_prod[s][f] = best;
         prod_ok[s][f] = 1'b1;
      end
      for (int m = 0; m < nmix; m++) begin
         for (int d = 0; d < DIM; d++) begin
            @(negedge clk);
            while (!p_ready) begin
               p_valid = 1'b0;
               @(negedge clk);
            end
            p_valid = 1'b1;
            p_mean = 8'(cur_mu[m][d]);
            p_ivar = 8'(cur_iv[m][d]);
            p_const = (d == 0) ? 16'(cur_c[m]) : 16'($urandom);
            if (d == DIM - 1) begin
               p_mix_last = (m == nmix - 1);
               p_batch_last = (m == nmix - 1) && last_st;
            end else begin
               p_mix_last = noise;
               p_batch_last = noise;
            end
         end
      end
      @(negedge clk);
      p_valid = 1'b0; p_mix_last = 1'b0; p_batch_last = 1'b0;
      if (last_st) begin
         #1 chk(done == 1'b1, "R6 done after last beat", int'(done), 1);
         @(negedge clk);
         #1 chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
      end
   endtask

   task automatic read_all(input int nst, input string tag);
      for (int s = 0; s < nst; s++) begin
         for (int f = 0; f < FR; f++) begin
            @(negedge clk);
            rd_state = 3'(s); rd_frame = 5'(f);
            #1 chk(int'($signed(rd_score)) == exp_view[s][f], tag,
                   int'($signed(rd_score)), exp_view[s][f]);
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      total++; bad++;
      $display("FAIL R6 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clear_prod();
      for (int s = 0; s < ST; s++)
         for (int f = 0; f < FR; f++) view_ok[s][f] = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(p_ready == 1'b1, "R9 reset p_ready", int'(p_ready), 1);
      chk(done == 1'b0, "R9 reset done", int'(done), 0);
      chk(res_swap == 1'b0, "R9 reset res_swap", int'(res_swap), 0);
      @(negedge clk);
      rst_n = 1'b1;
      live = 1'b1;

      // batch 1: random mixtures, consumer released from reset, swap at once
      load_feats();
      clear_prod();
      mix_mode = '{0, 0, 0, 0};
      run_state(0, 2, 1'b0, 1'b0);
      run_state(1, 1, 1'b0, 1'b0);
      run_state(2, 3, 1'b1, 1'b0);
      read_all(3, "R1 R3 scores");

      // batch 2: junk flags, saturation, per-state max restart, stall
      load_feats();
      clear_prod();
      mix_mode = '{3, 0, 0, 0};
      run_state(0, 1, 1'b0, 1'b1);
      mix_mode = '{1, 1, 0, 0};
      run_state(1, 2, 1'b0, 1'b1);
      mix_mode = '{2, 1, 0, 0};
      run_state(2, 2, 1'b0, 1'b1);
      mix_mode = '{0, 2, 0, 0};
      run_state(3, 2, 1'b1, 1'b1);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         p_valid = 1'b1; p_mix_last = 1'b1; p_batch_last = 1'b1;
         p_mean = 8'($urandom); p_const = 16'($urandom);
         #1 chk(p_ready == 1'b0, "R8 stalled", int'(p_ready), 0);
      end
      @(negedge clk);
      p_valid = 1'b0; p_mix_last = 1'b0; p_batch_last = 1'b0;
      read_all(3, "R7 old bank kept");
      @(negedge clk);
      cons_release = 1'b1;
      @(negedge clk);
      cons_release = 1'b0;
      #1 chk(res_swap == 1'b1, "R7 swap after release", int'(res_swap), 1);
      read_all(1, "R2 state score");
      read_all(2, "R2 max restarts per state");
      read_all(4, "R4 saturation and R5 flags");

      // batch 3: release early, alignment after the stall
      clear_prod();
      mix_mode = '{0, 0, 0, 0};
      run_state(0, 2, 1'b0, 1'b0);
      @(negedge clk);
      cons_release = 1'b1;
      @(negedge clk);
      cons_release = 1'b0;
      run_state(1, 1, 1'b1, 1'b0);
      read_all(2, "R8 restart alignment");

      repeat (4) @(negedge clk);
      live = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule